// File: doc/BRIEF.md
# Slack-Tracking PID Frequency Controller

This block chooses a clock frequency multiplier for each execution segment so that the timing debt caused by error recovery is paid back. When a segment finishes, the surrounding logic presents the segment's cycle budget and its count of wasted recovery cycles. The block folds these into a signed running slack. The slack is scaled by a power-of-two reference multiplier, so it needs only shifts and subtraction.

The negated slack is the control error, so a late-running sequence gives a positive error. A discrete PID update turns this error into a multiplier estimate. The proportional, integral and derivative terms each use a signed fixed-point gain. The estimate is clamped to a programmable window and then presented for the next segment. The integral accumulator is frozen whenever the estimate falls outside the window, which keeps it from winding up when the noise is too heavy to cancel.

Top module: `slack_pid_top`

## Requirements
- R1: On a cycle where `segValid` is high, the slack register is updated to `slack + (B >> K) - ((B + X) >> K)`. B is `segBudget`, X is `segNoise` (both unsigned) and K is `MREF_SHIFT` (default 2). The new value appears on `slackOut` after that clock edge.
- R2: Without `segValid`, `slackOut` holds its value. Because noise is never negative, an update never raises the slack.
- R3: The error is e = -slack. The estimate is P + (I + Ii) + D, where P = (e·kp) >>> 16, Ii = (e·ki) >>> 16 and D = ((e - ePrev)·kd) >>> 16. Gains are signed with 24 fractional bits, and the multiplier is unsigned with 8 fractional bits. Each shift is an arithmetic (floor) shift.
- R4: The published multiplier is the estimate clamped to [`multMin`, `multMax`].
- R5: The integral I is replaced by I + Ii only when the estimate lies inside the window. Otherwise I is kept.
- R6: `multValid` is a one-cycle pulse two clock edges after the edge that accepts `segValid`, and `multOut` changes only with that pulse. The stored previous error is updated with every pulse.
- R7: After reset, the slack is 0, the integral is 0, the previous error is 0, `multValid` is 0 and `multOut` is 256 (1.0).
- R8: Segments on consecutive cycles are each processed, in order, with one result pulse apiece.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| segValid | input | 1 | Segment-end strobe |
| segBudget | input | BUDGET_W | Cycle budget of the finished segment |
| segNoise | input | NOISE_W | Wasted recovery cycles of the finished segment |
| kp | input | GAIN_W | Proportional gain, signed Q.24 |
| ki | input | GAIN_W | Integral gain, signed Q.24 |
| kd | input | GAIN_W | Derivative gain, signed Q.24 |
| multMin | input | M_W | Lower clamp, Q.8 |
| multMax | input | M_W | Upper clamp, Q.8 |
| multOut | output | M_W | Frequency multiplier for the next segment, Q.8 |
| multValid | output | 1 | Result strobe |
| slackOut | output | SLACK_W | Running slack, signed cycles |

## Verification
The assertions check properties that hold on every cycle:
- the slack never rises and stays put between segments;
- every segment yields exactly one result pulse, two edges later;
- the multiplier holds between pulses and always lies inside the window that was programmed when it was computed.

The exact arithmetic can only be shown by the bench's scenarios. Those scenarios compare every slack and multiplier value with a fixed-point model, which covers truncation and the derivative term. They also show the frozen integral after saturation and the ordering of back-to-back segments.

// File: rtl/slack_pid_pkg.sv
package slack_pid_pkg;
  typedef struct packed {
    logic ldSlack;
    logic ldPid;
  } pidStrobe_t;
endpackage

// File: rtl/slack_pid_ctrl.sv
module slack_pid_ctrl
  import slack_pid_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       segValid,
  output pidStrobe_t strobe,
  output logic       multValid
);
  logic pidPend;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pidPend   <= 1'b0;
      multValid <= 1'b0;
    end else begin
      pidPend   <= segValid;
      multValid <= pidPend;
    end
  end

  always_comb begin
    strobe.ldSlack = segValid;
    strobe.ldPid   = pidPend;
  end
endmodule

// File: rtl/slack_pid_dp.sv
module slack_pid_dp
  import slack_pid_pkg::*;
#(
  parameter int BUDGET_W   = 24,
  parameter int NOISE_W    = 16,
  parameter int SLACK_W    = 32,
  parameter int GAIN_W     = 32,
  parameter int GAIN_FRAC  = 24,
  parameter int M_W        = 16,
  parameter int M_FRAC     = 8,
  parameter int ACC_W      = 48,
  parameter int MREF_SHIFT = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  pidStrobe_t                strobe,
  input  logic [BUDGET_W-1:0]       segBudget,
  input  logic [NOISE_W-1:0]        segNoise,
  input  logic signed [GAIN_W-1:0]  kp,
  input  logic signed [GAIN_W-1:0]  ki,
  input  logic signed [GAIN_W-1:0]  kd,
  input  logic [M_W-1:0]            multMin,
  input  logic [M_W-1:0]            multMax,
  output logic signed [SLACK_W-1:0] slackOut,
  output logic [M_W-1:0]            multOut
);
  localparam int SUM_W   = BUDGET_W + 1;
  localparam int PROD_W  = SLACK_W + 1 + GAIN_W;
  localparam int SHIFT   = GAIN_FRAC - M_FRAC;
  localparam logic [M_W-1:0] M_ONE = M_W'(1) << M_FRAC;

  // slack stage: shifts and subtraction only
  logic [SUM_W-1:0]          budgetExt, spent;
  logic [SLACK_W-1:0]        budgetScaled, spentScaled;
  logic signed [SLACK_W-1:0] slackQ, slackNext;

  always_comb begin
    budgetExt    = SUM_W'(segBudget);
    spent        = budgetExt + SUM_W'(segNoise);
    budgetScaled = SLACK_W'(budgetExt >> MREF_SHIFT);
    spentScaled  = SLACK_W'(spent >> MREF_SHIFT);
    slackNext    = slackQ + $signed(budgetScaled) - $signed(spentScaled);
  end

  // PID stage
  logic signed [SLACK_W-1:0] errNow, ePrevQ;
  logic signed [ACC_W-1:0]   intQ;
  logic signed [PROD_W-1:0]  errX, diffX, kpX, kiX, kdX, intX;
  logic signed [PROD_W-1:0]  pTerm, iInc, dTerm, iCand, mHat, minX, maxX;
  logic                      below, above;
  logic [M_W-1:0]            clampVal;

  always_comb begin
    errNow = -slackQ;
    errX   = {{(PROD_W-SLACK_W){errNow[SLACK_W-1]}}, errNow};
    diffX  = errX - {{(PROD_W-SLACK_W){ePrevQ[SLACK_W-1]}}, ePrevQ};
    kpX    = {{(PROD_W-GAIN_W){kp[GAIN_W-1]}}, kp};
    kiX    = {{(PROD_W-GAIN_W){ki[GAIN_W-1]}}, ki};
    kdX    = {{(PROD_W-GAIN_W){kd[GAIN_W-1]}}, kd};
    intX   = {{(PROD_W-ACC_W){intQ[ACC_W-1]}}, intQ};
    pTerm  = (errX * kpX) >>> SHIFT;
    iInc   = (errX * kiX) >>> SHIFT;
    dTerm  = (diffX * kdX) >>> SHIFT;
    iCand  = intX + iInc;
    mHat   = pTerm + iCand + dTerm;
    minX   = {{(PROD_W-M_W){1'b0}}, multMin};
    maxX   = {{(PROD_W-M_W){1'b0}}, multMax};
    above  = mHat > maxX;
    below  = mHat < minX;
    if (above)      clampVal = multMax;
    else if (below) clampVal = multMin;
    else            clampVal = mHat[M_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slackQ  <= '0;
      ePrevQ  <= '0;
      intQ    <= '0;
      multOut <= M_ONE;
    end else begin
      if (strobe.ldSlack) slackQ <= slackNext;
      if (strobe.ldPid) begin
        multOut <= clampVal;
        ePrevQ  <= errNow;
        if (!(above || below)) intQ <= iCand[ACC_W-1:0];
      end
    end
  end

  assign slackOut = slackQ;
endmodule

// File: rtl/slack_pid_top.sv
module slack_pid_top
  import slack_pid_pkg::*;
#(
  parameter int BUDGET_W   = 24,
  parameter int NOISE_W    = 16,
  parameter int SLACK_W    = 32,
  parameter int GAIN_W     = 32,
  parameter int GAIN_FRAC  = 24,
  parameter int M_W        = 16,
  parameter int M_FRAC     = 8,
  parameter int ACC_W      = 48,
  parameter int MREF_SHIFT = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      segValid,
  input  logic [BUDGET_W-1:0]       segBudget,
  input  logic [NOISE_W-1:0]        segNoise,
  input  logic signed [GAIN_W-1:0]  kp,
  input  logic signed [GAIN_W-1:0]  ki,
  input  logic signed [GAIN_W-1:0]  kd,
  input  logic [M_W-1:0]            multMin,
  input  logic [M_W-1:0]            multMax,
  output logic [M_W-1:0]            multOut,
  output logic                      multValid,
  output logic signed [SLACK_W-1:0] slackOut
);
  pidStrobe_t strobe;

  slack_pid_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .segValid(segValid),
    .strobe(strobe), .multValid(multValid)
  );

  slack_pid_dp #(
    .BUDGET_W(BUDGET_W), .NOISE_W(NOISE_W), .SLACK_W(SLACK_W),
    .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC), .M_W(M_W), .M_FRAC(M_FRAC),
    .ACC_W(ACC_W), .MREF_SHIFT(MREF_SHIFT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .segBudget(segBudget), .segNoise(segNoise),
    .kp(kp), .ki(ki), .kd(kd),
    .multMin(multMin), .multMax(multMax),
    .slackOut(slackOut), .multOut(multOut)
  );
endmodule

// File: rtl/slack_pid_chk.sv
module slack_pid_chk #(
  parameter int SLACK_W = 32,
  parameter int M_W     = 16
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      segValid,
  input logic [M_W-1:0]            multMin,
  input logic [M_W-1:0]            multMax,
  input logic [M_W-1:0]            multOut,
  input logic                      multValid,
  input logic signed [SLACK_W-1:0] slackOut
);
  a_r2_slack_hold: assert property (@(posedge clk) disable iff (!rstN)
    !segValid |=> $stable(slackOut));

  a_r2_slack_never_rises: assert property (@(posedge clk) disable iff (!rstN)
    segValid |=> slackOut <= $past(slackOut));

  a_r6_pulse_after_two: assert property (@(posedge clk) disable iff (!rstN)
    segValid |=> ##1 multValid);

  a_r6_mult_hold: assert property (@(posedge clk) disable iff (!rstN)
    !multValid |-> $stable(multOut));

  a_r4_in_window: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(multValid) && $past(multMin) <= $past(multMax)) |->
      (multOut >= $past(multMin) && multOut <= $past(multMax)));
endmodule

bind slack_pid_top slack_pid_chk #(.SLACK_W(SLACK_W), .M_W(M_W)) u_chk (
  .clk(clk), .rstN(rstN), .segValid(segValid),
  .multMin(multMin), .multMax(multMax),
  .multOut(multOut), .multValid(multValid), .slackOut(slackOut)
);

// File: tb/slack_pid_top_bench.sv
`timescale 1ns/1ps
module slack_pid_top_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic segValid = 1'b0;
  logic [23:0] segBudget = '0;
  logic [15:0] segNoise = '0;
  logic signed [31:0] kp, ki, kd;
  logic [15:0] multMin, multMax, multOut;
  logic multValid;
  logic signed [31:0] slackOut;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  longint mSlack, mInt, mEprev, mMult;
  bit mSat;

  always #2.5 clk = ~clk;

  slack_pid_top u_slack_pid_top (
    .clk(clk), .rstN(rstN), .segValid(segValid),
    .segBudget(segBudget), .segNoise(segNoise),
    .kp(kp), .ki(ki), .kd(kd),
    .multMin(multMin), .multMax(multMax),
    .multOut(multOut), .multValid(multValid), .slackOut(slackOut)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint slackStep(input longint s, input longint b, input longint x);
    return s + (b >> 2) - ((b + x) >> 2);
  endfunction

  // reference PID step on slack value s
  task automatic pidStep(input longint s);
    longint e, p, ii, d, cand, mh;
    e    = -s;
    p    = (e * longint'(kp)) >>> 16;
    ii   = (e * longint'(ki)) >>> 16;
    d    = ((e - mEprev) * longint'(kd)) >>> 16;
    cand = mInt + ii;
    mh   = p + cand + d;
    mSat = 1'b1;
    if (mh > longint'(multMax)) mMult = longint'(multMax);
    else if (mh < longint'(multMin)) mMult = longint'(multMin);
    else begin mMult = mh; mInt = cand; mSat = 1'b0; end
    mEprev = e;
  endtask

  task automatic modelReset();
    mSlack = 0; mInt = 0; mEprev = 0; mMult = 256;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    modelReset();
    check(slackOut == 0, "R7 slack", longint'(slackOut), 0);
    check(multOut == 16'd256, "R7 mult", longint'(multOut), 256);
    check(multValid == 1'b0, "R7 valid", longint'(multValid), 0);
  endtask

  task automatic runSeg(input longint b, input longint x, input string tag);
    segBudget = 24'(b);
    segNoise  = 16'(x);
    segValid  = 1'b1;
    @(negedge clk);
    segValid = 1'b0;
    mSlack = slackStep(mSlack, b, x);
    check(longint'(slackOut) == mSlack, {"R1 slack ", tag}, longint'(slackOut), mSlack);
    check(multValid == 1'b0, "R6 early", longint'(multValid), 0);
    @(negedge clk);
    pidStep(mSlack);
    check(multValid == 1'b1, "R6 pulse", longint'(multValid), 1);
    check(longint'(multOut) == mMult,
          mSat ? {"R4 R5 clamped ", tag} : {"R3 R5 mult ", tag},
          longint'(multOut), mMult);
    @(negedge clk);
    check(multValid == 1'b0 && longint'(multOut) == mMult, "R6 single pulse and hold",
          longint'(multValid), 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    longint pend [3];
    longint b, x;
    void'($urandom(32'd1234));
    kp = 32'sd65536;  // 2^-8
    ki = 32'sd8192;   // 2^-11
    kd = 32'sd32768;  // 2^-9
    multMin = 16'd64;
    multMax = 16'd1024;
    doReset();

    // directed: zero noise leaves slack at 0, estimate 0 clamps to min (R1, R4)
    runSeg(1000, 0, "zero noise");
    check(multOut == 16'd64, "R4 min clamp", longint'(multOut), 64);
    runSeg(1000, 8, "small burst");
    check(slackOut == -2, "R1 floor scaling", longint'(slackOut), -2);

    // R2: idle cycles leave slack unchanged
    repeat (5) @(negedge clk);
    check(longint'(slackOut) == mSlack, "R2 hold", longint'(slackOut), mSlack);

    // random scripted bursts
    for (int i = 0; i < 80; i++) begin
      b = 100 + ($urandom % 5000);
      x = (($urandom % 4) == 0) ? ($urandom % 200) : 0;
      runSeg(b, x, "random");
    end

    // heavy burst saturates at the ceiling, integral frozen (R4, R5)
    doReset();
    runSeg(4000, 60000, "heavy");
    check(multOut == 16'd1024, "R4 max clamp", longint'(multOut), 1024);
    // zero-gain proportional and derivative exposes the held integral
    kp = '0; kd = '0;
    multMax = 16'd60000;
    runSeg(4000, 0, "integral after windup R5");

    // R8 back-to-back segments
    kp = 32'sd65536; kd = -32'sd32768;
    multMax = 16'd2048;
    for (int i = 0; i < 3; i++) begin
      segBudget = 24'(500 + i * 100);
      segNoise  = 16'(40 * (i + 1));
      segValid  = 1'b1;
      mSlack = slackStep(mSlack, 500 + i * 100, 40 * (i + 1));
      pend[i] = mSlack;
      @(negedge clk);
      check(longint'(slackOut) == pend[i], "R8 slack order", longint'(slackOut), pend[i]);
      if (i > 0) begin
        pidStep(pend[i-1]);
        check(multValid && longint'(multOut) == mMult, "R8 mult order",
              longint'(multOut), mMult);
      end
    end
    segValid = 1'b0;
    @(negedge clk);
    pidStep(pend[2]);
    check(multValid && longint'(multOut) == mMult, "R8 last mult", longint'(multOut), mMult);
    @(negedge clk);
    check(multValid == 1'b0, "R8 pulses end", longint'(multValid), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule